// File: doc/BRIEF.md
# Carry-Predicting Block Lookahead Adder

This block is a registered 16-bit binary adder. It is built from four 4-bit carry lookahead groups. The two operands and a carry-in are captured into an input register. The addition is evaluated in one register-to-register stage. The sum, the final carry and one prediction-valid flag per group are captured into an output register one clock later.

Each group forwards a carry to the next-higher group without waiting for its own top in-group carry. An early predictor looks only at the group's upper three operand bit pairs. It decides whether those pairs alone generate or kill the group's carry. Prediction is impossible only when all three upper pairs propagate. In that case the group forwards the carry out of its lowest bit position instead, because in that case the lowest carry equals the group's true carry-out. The multiplexer select is the NAND of the three upper propagates. A group therefore never builds logic for its fourth in-group carry.

The flags show, for every result, which groups forwarded a predicted carry and which fell back. They are meant for callers that care about the data-dependent path, such as timing characterisation or coverage collection.

Top module: `clap_adder`

## Requirements
- R1: One clock edge after operands `op_a`, `op_b` and `carry_in` are captured, `sum_o` equals the low 16 bits of `op_a + op_b + carry_in`.
- R2: In the same cycle as R1, `carry_o` equals bit 16 of `op_a + op_b + carry_in`. This holds both when the top group predicts and when it falls back to its lowest-position carry.
- R3: `pred_ok_o[g]`, for g = 0..3, is registered alongside the sum. It is 0 exactly when operand bits 4g+1, 4g+2 and 4g+3 all have `op_a` differing from `op_b`, and 1 otherwise.
- R4: When every bit has `op_a` differing from `op_b`, all four flags are 0. The result is then 0xFFFF with carry 0 for `carry_in` = 0, and 0x0000 with carry 1 for `carry_in` = 1.
- R5: While `rst` (active high, synchronous) is sampled high, the next edge sets `sum_o`, `carry_o` and `pred_ok_o` to zero.
- R6: Back-to-back operand sets presented on consecutive clocks give results on consecutive clocks, in the same order, with no stall.
- R7: The carry each group forwards equals the true carry out of all operand bits below that group's boundary, computed with `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Registered sum |
| carry_o | output | 1 | Registered carry out of bit 15 |
| pred_ok_o | output | 4 | Registered per-group prediction-valid flags |

## Verification
The bench sweeps all 256 operand patterns of one 4-bit group with both carry-in values, in each of the four group positions, while the other bits are random. This covers every predict and fallback combination. A predictor with a wrong product term, or a fallback that picks the wrong in-group carry, would give wrong sums in the next group only for particular upper bit pairs, and the sweep reaches all of those pairs. The all-propagate operand pairs force every group to fall back at once, so that carry-in must ripple through the whole word; a design that forwarded a stale or predicted carry there would return 0xFFFF instead of zero with a carry. A pipelined back-to-back sequence would expose mixed-up register stages, and a mid-run reset would expose flags left uncleared.

// File: rtl/clap_pkg.sv
package clap_pkg;

  localparam int GRP_W = 4;

  // Early carry decision from the upper three bit pairs of a group.
  function automatic logic predict_co(input logic [GRP_W-1:0] a, input logic [GRP_W-1:0] b);
    logic g1, g2, g3, o2, o3;
    g1 = a[1] & b[1];
    g2 = a[2] & b[2];
    g3 = a[3] & b[3];
    o2 = a[2] | b[2];
    o3 = a[3] | b[3];
    return g3 | (g2 & o3) | (g1 & o2 & o3);
  endfunction

  // Lookahead carries out of local bits 0..2 (the top carry is never built).
  function automatic logic [2:0] low_carries(input logic [GRP_W-1:0] g,
                                             input logic [GRP_W-1:0] p,
                                             input logic cin);
    logic [2:0] c;
    c[0] = g[0] | (p[0] & cin);
    c[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    c[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & cin);
    return c;
  endfunction

  // Select for the forwarding mux: 1 when the prediction can be trusted.
  function automatic logic can_predict(input logic [GRP_W-1:0] p);
    return ~(p[1] & p[2] & p[3]);
  endfunction

endpackage

// File: rtl/clap_gp.sv
module clap_gp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/clap_group.sv
module clap_group
  import clap_pkg::*;
(
  input  logic [GRP_W-1:0] a,
  input  logic [GRP_W-1:0] b,
  input  logic [GRP_W-1:0] gen,
  input  logic [GRP_W-1:0] prop,
  input  logic             cin,
  output logic [GRP_W-1:0] sum,
  output logic             fwd,
  output logic             pred_ok
);
  logic [2:0] carries;
  logic       predicted;

  assign carries   = low_carries(gen, prop, cin);
  assign predicted = predict_co(a, b);
  assign pred_ok   = can_predict(prop);
  assign fwd       = pred_ok ? predicted : carries[0];
  assign sum       = prop ^ {carries, cin};
endmodule

// File: rtl/clap_adder.sv
module clap_adder
  import clap_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic [WIDTH/GRP_W-1:0] pred_ok_o
);
  localparam int NGRP = WIDTH / GRP_W;

  logic [WIDTH-1:0] a_q, b_q;
  logic             cin_q;
  logic [WIDTH-1:0] gen, prop, sum_d;
  logic [NGRP:0]    chain;
  logic [NGRP-1:0]  pred_ok_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= 1'b0;
    end else begin
      a_q   <= op_a;
      b_q   <= op_b;
      cin_q <= carry_in;
    end
  end

  clap_gp #(.WIDTH(WIDTH)) gp_i (.a(a_q), .b(b_q), .gen(gen), .prop(prop));

  assign chain[0] = cin_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    clap_group grp_i (
      .a      (a_q[g*GRP_W +: GRP_W]),
      .b      (b_q[g*GRP_W +: GRP_W]),
      .gen    (gen[g*GRP_W +: GRP_W]),
      .prop   (prop[g*GRP_W +: GRP_W]),
      .cin    (chain[g]),
      .sum    (sum_d[g*GRP_W +: GRP_W]),
      .fwd    (chain[g+1]),
      .pred_ok(pred_ok_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o     <= '0;
      carry_o   <= 1'b0;
      pred_ok_o <= '0;
    end else begin
      sum_o     <= sum_d;
      carry_o   <= chain[NGRP];
      pred_ok_o <= pred_ok_d;
    end
  end
endmodule

// File: rtl/clap_adder_chk.sv
module clap_adder_chk #(
  parameter int WIDTH = 16,
  parameter int GW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q,
  input logic             cin_q,
  input logic [WIDTH/GW:0] chain,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic [WIDTH/GW-1:0] pred_ok_o
);
  localparam int NGRP = WIDTH / GW;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q};

  logic [NGRP-1:0] ref_flags;
  for (genvar g = 0; g < NGRP; g++) begin : g_flag
    assign ref_flags[g] = ~&(a_q[g*GW+1 +: GW-1] ^ b_q[g*GW+1 +: GW-1]);
  end

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> sum_o == $past(ref_total[WIDTH-1:0]));

  // R2
  carry_value_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> carry_o == $past(ref_total[WIDTH]));

  // R3
  flag_value_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> pred_ok_o == $past(ref_flags));

  // R4
  all_prop_chk: assert property (@(posedge clk) disable iff (rst)
    (&(a_q ^ b_q)) |=> (pred_ok_o == '0));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !carry_o && pred_ok_o == '0));

  // R7
  for (genvar g = 1; g <= NGRP; g++) begin : g_fwd
    logic [g*GW:0] part;
    assign part = {1'b0, a_q[g*GW-1:0]} + {1'b0, b_q[g*GW-1:0]} + {{(g*GW){1'b0}}, cin_q};
    forward_carry_chk: assert property (@(posedge clk) disable iff (rst)
      chain[g] == part[g*GW]);
  end
endmodule

bind clap_adder clap_adder_chk #(.WIDTH(WIDTH), .GW(clap_pkg::GRP_W)) chk_i (
  .clk(clk), .rst(rst), .a_q(a_q), .b_q(b_q), .cin_q(cin_q), .chain(chain),
  .sum_o(sum_o), .carry_o(carry_o), .pred_ok_o(pred_ok_o)
);

// File: tb/clap_adder_tb_top.sv
module clap_adder_tb_top;
  localparam int W = 16;
  localparam int NG = W / 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  op_a = '0, op_b = '0;
  logic          carry_in = 1'b0;
  logic [W-1:0]  sum_o;
  logic          carry_o;
  logic [NG-1:0] pred_ok_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  clap_adder #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_o(sum_o), .carry_o(carry_o), .pred_ok_o(pred_ok_o)
  );

  function automatic logic [W:0] exp_total(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    int unsigned t;
    t = int'(a) + int'(b) + int'(c);
    return t[W:0];
  endfunction

  function automatic logic [NG-1:0] exp_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [NG-1:0] f;
    for (int g = 0; g < NG; g++) begin
      f[g] = 1'b1;
      if (a[4*g+1] != b[4*g+1] && a[4*g+2] != b[4*g+2] && a[4*g+3] != b[4*g+3]) f[g] = 1'b0;
    end
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] t;
    t = exp_total(a, b, c);
    check({tag, " R1 sum"}, 32'(sum_o), 32'(t[W-1:0]));
    check({tag, " R2 carry"}, 32'(carry_o), 32'(t[W]));
    check({tag, " R3 flags"}, 32'(pred_ok_o), 32'(exp_flags(a, b)));
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    op_a = a; op_b = b; carry_in = c;
  endtask

  task automatic apply(input string tag, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    drive(a, b, c);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_result(tag, a, b, c);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] a, b, a2, b2;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 sum", 32'(sum_o), 0);
    check("R5 carry", 32'(carry_o), 0);
    check("R5 flags", 32'(pred_ok_o), 0);
    rst = 1'b0;

    // R7 / R1 / R2: exhaustive 4-bit group sweep in each position
    for (int g = 0; g < NG; g++) begin
      for (int v = 0; v < 256; v++) begin
        for (int c = 0; c < 2; c++) begin
          a = W'($urandom);
          b = W'($urandom);
          a[4*g +: 4] = v[3:0];
          b[4*g +: 4] = v[7:4];
          apply("R7 sweep", a, b, c[0]);
        end
      end
    end

    // R4: all-propagate patterns, every group falls back
    apply("R4 allprop", 16'h0000, 16'hFFFF, 1'b0);
    check("R4 sum zero-cin", 32'(sum_o), 32'hFFFF);
    apply("R4 allprop", 16'h0000, 16'hFFFF, 1'b1);
    check("R4 sum one-cin", 32'(sum_o), 32'h0000);
    check("R4 carry one-cin", 32'(carry_o), 1);
    check("R4 flags", 32'(pred_ok_o), 0);
    for (int i = 0; i < 40; i++) begin
      a = W'($urandom);
      apply("R4 allprop rnd", a, ~a, i[0]);
    end

    // R1 / R2: boundary values
    apply("R2 max", 16'hFFFF, 16'hFFFF, 1'b1);
    apply("R2 max", 16'hFFFF, 16'h0001, 1'b0);
    apply("R1 zero", 16'h0000, 16'h0000, 1'b0);
    apply("R1 zero", 16'h0000, 16'h0000, 1'b1);

    // R1 / R2 / R3: random vectors
    for (int i = 0; i < 2000; i++) apply("R1 rnd", W'($urandom), W'($urandom), 1'($urandom));

    // R6: back-to-back results in order
    for (int i = 0; i < 50; i++) begin
      a = W'($urandom); b = W'($urandom);
      a2 = W'($urandom); b2 = ~a2;
      drive(a, b, 1'b1);
      @(negedge clk); drive(a2, b2, 1'b1);
      @(negedge clk); check_result("R6 first", a, b, 1'b1);
      @(negedge clk); check_result("R6 second", a2, b2, 1'b1);
    end

    // R5: mid-run reset clears registered results
    apply("R1 pre-reset", 16'hBEEF, 16'h1234, 1'b1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R5 mid sum", 32'(sum_o), 0);
    check("R5 mid carry", 32'(carry_o), 0);
    check("R5 mid flags", 32'(pred_ok_o), 0);
    rst = 1'b0;
    apply("R1 post-reset", 16'h8001, 16'h7FFF, 1'b0);

    finish_run();
  end
endmodule